// File: doc/BRIEF.md
# Input port change detector

This block watches a small general-purpose input port, filters each line against short glitches, and reports both the filtered levels and any accepted transition on the lowest four lines. Every pin goes through a two-stage synchroniser. A per-pin counter then lets a new level through only after it has held for a set number of clock cycles. Either a rising or a falling edge on a watched line, once accepted, sets a sticky flag for that line.

Software sees two read words. The port word gives the filtered level of every pin, with a constant 1 in its top bit. The change word packs the sticky flags above the current levels of the four watched lines. A per-line enable vector decides which flags may drive the interrupt request. A one-cycle read strobe on the change word clears the flags and the request. The clear does not lose a transition that is accepted in the same cycle as the strobe: that flag stays set for the next read.

Top module: `inport_watch`

## Requirements
- R1: After reset `port_o` reads 8'h80, `chg_o` reads 8'h00 and `irq_o` is 0.
- R2: `port_o[7]` is always 1, and `port_o[6:0]` holds the filtered level of `pin_i[6:0]`.
- R3: A pin level passes two synchroniser flops and must then stay the same for FILT_CNT (default 3) consecutive cycles before the filtered level takes it. A pin pulse shorter than FILT_CNT cycles never changes the filtered level. With the defaults, a change driven ahead of a clock edge appears on `port_o` after the fifth rising edge and not before it.
- R4: An accepted rising or falling edge on pin i, for i in 0 to 3, sets `chg_o[4+i]`. `chg_o[3:0]` holds the filtered levels of pins 3 to 0.
- R5: Changes on pins 4 to 6 never set any bit of `chg_o[7:4]`.
- R6: `irq_o` is 1 exactly when some flag `chg_o[4+i]` is set while `irq_en_i[i]` is 1. Changing `irq_en_i` takes effect in the same cycle.
- R7: A clock edge with `chg_rd_i` high clears `chg_o[7:4]`, and `irq_o` falls with them.
- R8: A transition accepted at the same edge as a read strobe leaves its flag set after that edge. Flags that were set before the strobe are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 7 | Raw asynchronous input pins |
| irq_en_i | input | 4 | Interrupt enable for pins 3 to 0 |
| chg_rd_i | input | 1 | One-cycle strobe marking a read of the change word |
| port_o | output | 8 | Constant 1 in bit 7, filtered pin levels in bits 6:0 |
| chg_o | output | 8 | Sticky change flags in bits 7:4, filtered levels of pins 3:0 in bits 3:0 |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench applies a two-cycle pulse, which must disappear. A filter counter that is off by one would let it through, or would shift the exact edge at which a longer change arrives. The bench also raises a read strobe at the very edge where a new transition is accepted. A design that puts the clear ahead of the set would then lose that flag, and one that skips the clear in that cycle would keep the older flag set. The remaining tests move only the upper pins, which must never set a flag, and change the enable mask while a flag is pending, which must move the interrupt request at once.

// File: rtl/inport_pkg.sv
package inport_pkg;

  function automatic logic [7:0] port_word(input logic [6:0] lvl);
    return {1'b1, lvl};
  endfunction

  function automatic logic [7:0] chg_word(input logic [3:0] flg, input logic [3:0] lvl);
    return {flg, lvl};
  endfunction

  function automatic logic irq_any(input logic [3:0] flg, input logic [3:0] en);
    return |(flg & en);
  endfunction

endpackage

// File: rtl/inport_sync.sv
module inport_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/inport_filter.sv
module inport_filter #(
  parameter int FILT_CNT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic s_i,
  output logic lvl_o,
  output logic upd_o
);
  localparam int CW = $clog2(FILT_CNT + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CNT - 1);

  logic [CW-1:0] cnt_q;
  logic          lvl_q;
  logic          diff;

  assign diff  = (s_i != lvl_q);
  assign upd_o = diff && (cnt_q == LAST);
  assign lvl_o = lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (upd_o) begin
      cnt_q <= '0;
      lvl_q <= s_i;
    end else if (diff) begin
      cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/inport_flags.sv
module inport_flags #(
  parameter int NUM_DET = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DET-1:0] upd_i,
  input  logic               clr_i,
  output logic [NUM_DET-1:0] flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= '0;
    else flag_o <= (flag_o & ~{NUM_DET{clr_i}}) | upd_i;
  end
endmodule

// File: rtl/inport_watch.sv
module inport_watch
  import inport_pkg::*;
#(
  parameter int NUM_IN      = 7,
  parameter int NUM_DET     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CNT    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IN-1:0]  pin_i,
  input  logic [NUM_DET-1:0] irq_en_i,
  input  logic               chg_rd_i,
  output logic [NUM_IN:0]    port_o,
  output logic [2*NUM_DET-1:0] chg_o,
  output logic               irq_o
);
  logic [NUM_IN-1:0]  sync_q;
  logic [NUM_IN-1:0]  deb_q;
  logic [NUM_IN-1:0]  upd_w;
  logic [NUM_DET-1:0] flag_q;

  inport_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(sync_q)
  );

  for (genvar i = 0; i < NUM_IN; i++) begin : g_filt
    inport_filter #(.FILT_CNT(FILT_CNT)) u_filt (
      .clk(clk), .rst_n(rst_n), .s_i(sync_q[i]),
      .lvl_o(deb_q[i]), .upd_o(upd_w[i])
    );
  end

  inport_flags #(.NUM_DET(NUM_DET)) u_flags (
    .clk(clk), .rst_n(rst_n), .upd_i(upd_w[NUM_DET-1:0]),
    .clr_i(chg_rd_i), .flag_o(flag_q)
  );

  assign port_o = port_word(deb_q);
  assign chg_o  = chg_word(flag_q, deb_q[NUM_DET-1:0]);
  assign irq_o  = irq_any(flag_q, irq_en_i);
endmodule

// File: rtl/inport_watch_chk.sv
module inport_watch_chk #(
  parameter int NUM_IN  = 7,
  parameter int NUM_DET = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               chg_rd_i,
  input logic [NUM_IN-1:0]  sync_lvl,
  input logic [NUM_IN-1:0]  deb_lvl,
  input logic [NUM_IN-1:0]  upd,
  input logic [NUM_DET-1:0] flags,
  input logic               irq_o
);
  p_filter_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(deb_lvl) |-> (deb_lvl == $past(sync_lvl)));

  p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|upd[NUM_DET-1:0]) |=> ((flags & $past(upd[NUM_DET-1:0])) == $past(upd[NUM_DET-1:0])));

  p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd[NUM_DET-1:0] == '0) |=> ((flags & ~$past(flags)) == '0));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_rd_i && (upd[NUM_DET-1:0] == '0)) |=> ((flags == '0) && !irq_o));

  p_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chg_rd_i |=> (flags == $past(upd[NUM_DET-1:0])));
endmodule

bind inport_watch inport_watch_chk #(.NUM_IN(NUM_IN), .NUM_DET(NUM_DET)) u_chk (
  .clk(clk), .rst_n(rst_n), .chg_rd_i(chg_rd_i), .sync_lvl(sync_q),
  .deb_lvl(deb_q), .upd(upd_w), .flags(flag_q), .irq_o(irq_o)
);

// File: tb/inport_watch_tb.sv
`timescale 1ns/1ps
module inport_watch_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] pin_i = '0;
  logic [3:0] irq_en_i = '0;
  logic       chg_rd_i = 1'b0;
  logic [7:0] port_o;
  logic [7:0] chg_o;
  logic       irq_o;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  inport_watch u_dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .irq_en_i(irq_en_i),
    .chg_rd_i(chg_rd_i), .port_o(port_o), .chg_o(chg_o), .irq_o(irq_o)
  );

  // {pins[6:0], en[3:0], port[7:0], chg[7:0], irq}
  localparam int NV = 6;
  localparam logic [27:0] VEC [NV] = '{
    {7'b0000001, 4'b0001, 8'h81, 8'h11, 1'b1},
    {7'b0000011, 4'b0001, 8'h83, 8'h23, 1'b0},
    {7'b0000010, 4'b0001, 8'h82, 8'h12, 1'b1},
    {7'b1110010, 4'b1111, 8'hF2, 8'h02, 1'b0},
    {7'b1111101, 4'b1000, 8'hFD, 8'hFD, 1'b1},
    {7'b0001101, 4'b0100, 8'h8D, 8'h0D, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_pulse();
    chg_rd_i = 1'b1;
    step(1);
    chg_rd_i = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        fails++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    step(2);
    check("R1 port", port_o, 8'h80);
    check("R1 chg", chg_o, 8'h00);
    check("R1 irq", {7'd0, irq_o}, 8'h00);
    rst_n = 1'b1;
    step(2);

    // R2 R4 R5 R6 R7: table walk
    for (int v = 0; v < NV; v++) begin
      pin_i    = VEC[v][27:21];
      irq_en_i = VEC[v][20:17];
      step(8);
      check("R2 port", port_o, VEC[v][16:9]);
      check("R4 chg", chg_o, VEC[v][8:1]);
      check("R6 irq", {7'd0, irq_o}, {7'd0, VEC[v][0]});
      rd_pulse();
      check("R7 cleared", {chg_o[7:4], 3'd0, irq_o}, 8'h00);
    end

    // R3: two-cycle glitch on pin1 is rejected
    pin_i[1] = 1'b1;
    step(2);
    pin_i[1] = 1'b0;
    step(8);
    check("R3 glitch", chg_o, 8'h0D);
    check("R3 glitch port", port_o, 8'h8D);

    // R3: exact latency, five rising edges
    pin_i[1] = 1'b1;
    step(4);
    check("R3 early", port_o, 8'h8D);
    step(1);
    check("R3 arrive", port_o, 8'h8F);
    step(2);
    rd_pulse();

    // R8: read coincides with acceptance of a new edge
    pin_i[2] = 1'b0;
    step(8);
    check("R8 setup", chg_o, 8'h4B);
    pin_i[0] = 1'b0;
    step(4);
    rd_pulse();
    check("R8 kept", chg_o, 8'h1A);
    rd_pulse();
    check("R8 next read", chg_o, 8'h0A);

    // R6: enable change acts at once
    irq_en_i = 4'b0000;
    pin_i[3] = 1'b0;
    step(8);
    check("R6 masked", {chg_o[7:4], 3'd0, irq_o}, 8'h80);
    irq_en_i = 4'b1000;
    step(1);
    check("R6 unmasked", {7'd0, irq_o}, 8'h01);
    rd_pulse();
    check("R7 irq drop", {7'd0, irq_o}, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule